// File: doc/BRIEF.md
# Quad DAC Serial Load Controller

This block is the digital front end of a four-channel, 12-bit converter. A host shifts 16-bit words in on a serial data pin, clocked by a serial clock that only has effect while the active-low chip select is low. Each word carries a 2-bit channel address and a 12-bit code. A falling edge on the separate active-low load strobe copies the code into the addressed channel register, whatever chip select is doing. An active-low clear forces all four channel registers to zero or to midscale. A run-time select input chooses which of the two values is used. The clear does not touch the shift register.

All six control and data pins are asynchronous to the block. They are brought through a multi-stage synchronizer onto the block clock. Edges on the serial clock and on the load strobe are then found by comparing each synchronized level with its value one cycle earlier. The four channel register values are the outputs.

Top module: `qdac_front`

## Requirements
- R1: On each rising edge of `sclk` while `cs_n` is low, `sdi` is shifted into a 16-bit shift register, most significant bit first. A word is laid out as bit 15 = A1, bit 14 = A0, bits 13:12 unused, bits 11:0 = code sent most significant bit first.
- R2: While `cs_n` is high, edges on `sclk` and the value on `sdi` are ignored, and the shift register keeps its contents.
- R3: A falling edge of `ld_n` writes shift register bits 11:0 into the channel that bits 15:14 select (0 = A, 1 = B, 2 = C, 3 = D). This happens at either level of `cs_n`.
- R4: A load changes only the addressed channel. The other three keep their values.
- R5: While `clr_n` is low, all four channels are forced to 0x800 if `clr_mid` is high, and to 0x000 if it is low.
- R6: Clear leaves the shift register unchanged. A load after a clear, with no new shifting, writes the word shifted in before the clear.
- R7: A falling edge of `ld_n` that occurs while `clr_n` is low has no effect. The channels hold the clear value.
- R8: After reset, all channels and the shift register are zero.
- R9: When more than 16 bits are shifted in one select window, only the last 16 bits are kept.
- R10: An edge at the pins reaches the outputs within SYNC_STAGES + 2 clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| sdi | input | 1 | Serial data |
| sclk | input | 1 | Serial clock, rising edge active |
| cs_n | input | 1 | Active-low chip select, gates `sclk` |
| ld_n | input | 1 | Active-low load strobe, falling edge active |
| clr_n | input | 1 | Active-low clear |
| clr_mid | input | 1 | Clear value select: 1 = midscale, 0 = zero |
| dac_a | output | 12 | Channel A register |
| dac_b | output | 12 | Channel B register |
| dac_c | output | 12 | Channel C register |
| dac_d | output | 12 | Channel D register |

## Verification
The assertions check the following on every cycle, working on the synchronized levels:
- a held clear forces the chosen value one cycle later;
- a load edge under clear changes nothing;
- a load edge places the shifted code in the addressed channel;
- no more than one channel changes per cycle outside a clear;
- the shift register does not move while select is high.

Only the bench scenarios can show end-to-end behaviour at the pins. These include the serial bit order and word layout, words longer than 16 bits, loads taken with select held low, and a shifted word surviving a clear. The bench checks each of these against a reference model of all four channels and the shift register.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    parameter int DW = 12;
    parameter int AW = 2;
    parameter int WW = 16;
    parameter int SYNC_STAGES = 2;
    localparam int NCH = 1 << AW;

    typedef logic [DW-1:0] code_t;
    typedef logic [AW-1:0] addr_t;
    typedef logic [WW-1:0] word_t;

    function automatic code_t clear_code(input logic mid);
        return mid ? code_t'(code_t'(1) << (DW - 1)) : '0;
    endfunction
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st_q[i] <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q[STAGES-1];
endmodule

// File: rtl/qdac_shift.sv
module qdac_shift
    import qdac_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sclk_s,
    input  logic  cs_s,
    input  logic  sdi_s,
    output addr_t addr_q,
    output code_t code_q
);
    typedef struct packed {
        word_t sr;
        logic  sclk_prev;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic      shift_en;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_s;
        shift_en       = sclk_s && !st_q.sclk_prev && !cs_s;
        if (shift_en) begin
            st_d.sr = {st_q.sr[WW-2:0], sdi_s};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_q = st_q.sr[WW-1 -: AW];
    assign code_q = st_q.sr[DW-1:0];
endmodule

// File: rtl/qdac_bank.sv
module qdac_bank
    import qdac_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ld_s,
    input  logic                   clr_s,
    input  logic                   clr_mid_s,
    input  addr_t                  addr_q,
    input  code_t                  code_q,
    output logic [NCH-1:0][DW-1:0] ch_q
);
    typedef struct packed {
        logic [NCH-1:0][DW-1:0] ch;
        logic                   ld_prev;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic     ld_fall;

    always_comb begin
        st_d         = st_q;
        st_d.ld_prev = ld_s;
        ld_fall      = !ld_s && st_q.ld_prev;
        if (!clr_s) begin
            for (int i = 0; i < NCH; i++) st_d.ch[i] = clear_code(clr_mid_s);
        end else if (ld_fall) begin
            st_d.ch[addr_q] = code_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ch      <= '0;
            st_q.ld_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ch_q = st_q.ch;
endmodule

// File: rtl/qdac_front.sv
module qdac_front
    import qdac_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sdi,
    input  logic          sclk,
    input  logic          cs_n,
    input  logic          ld_n,
    input  logic          clr_n,
    input  logic          clr_mid,
    output logic [DW-1:0] dac_a,
    output logic [DW-1:0] dac_b,
    output logic [DW-1:0] dac_c,
    output logic [DW-1:0] dac_d
);
    localparam int NIN = 6;
    // idle levels: clr_mid=0, clr_n=1, ld_n=1, cs_n=1, sclk=0, sdi=0
    localparam logic [NIN-1:0] IDLE = 6'b011100;

    logic [NIN-1:0]         in_s;
    logic                   clr_mid_s, clr_s, ld_s, cs_s, sclk_s, sdi_s;
    addr_t                  addr_q;
    code_t                  code_q;
    logic [NCH-1:0][DW-1:0] ch_q;
    logic [DW-1:0]          ch_out [NCH];

    qdac_sync #(.W(NIN), .STAGES(SYNC_STAGES), .RST_VAL(IDLE)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({clr_mid, clr_n, ld_n, cs_n, sclk, sdi}),
        .dout (in_s)
    );

    assign {clr_mid_s, clr_s, ld_s, cs_s, sclk_s, sdi_s} = in_s;

    qdac_shift u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk_s(sclk_s),
        .cs_s  (cs_s),
        .sdi_s (sdi_s),
        .addr_q(addr_q),
        .code_q(code_q)
    );

    qdac_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_s     (ld_s),
        .clr_s    (clr_s),
        .clr_mid_s(clr_mid_s),
        .addr_q   (addr_q),
        .code_q   (code_q),
        .ch_q     (ch_q)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_out
        assign ch_out[g] = ch_q[g];
    end

    assign dac_a = ch_out[0];
    assign dac_b = ch_out[1];
    assign dac_c = ch_out[2];
    assign dac_d = ch_out[3];
endmodule

// File: rtl/qdac_front_chk.sv
module qdac_front_chk
    import qdac_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          clr_s,
    input logic          ld_s,
    input logic          cs_s,
    input logic          clr_mid_s,
    input addr_t         addr_q,
    input code_t         code_q,
    input logic [DW-1:0] dac_a,
    input logic [DW-1:0] dac_b,
    input logic [DW-1:0] dac_c,
    input logic [DW-1:0] dac_d
);
    logic ld_prev;
    logic ld_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ld_prev <= 1'b1;
        else        ld_prev <= ld_s;
    end

    assign ld_edge = ld_prev && !ld_s;

    function automatic code_t pick(input addr_t a, input code_t c0, input code_t c1,
                                   input code_t c2, input code_t c3);
        case (a)
            2'd0:    return c0;
            2'd1:    return c1;
            2'd2:    return c2;
            default: return c3;
        endcase
    endfunction

    // R5
    clear_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_s |=> (dac_a == clear_code($past(clr_mid_s)) && dac_b == clear_code($past(clr_mid_s))
                 && dac_c == clear_code($past(clr_mid_s)) && dac_d == clear_code($past(clr_mid_s))));

    // R7
    clear_blocks_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_s && ld_edge) |=> (dac_a == clear_code($past(clr_mid_s))));

    // R3
    load_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_s && ld_edge) |=> (pick($past(addr_q), dac_a, dac_b, dac_c, dac_d) == $past(code_q)));

    // R4
    one_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_s |=> ($countones({dac_a != $past(dac_a), dac_b != $past(dac_b),
                               dac_c != $past(dac_c), dac_d != $past(dac_d)}) <= 1));

    // R4
    no_edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_s && !ld_edge) |=> $stable({dac_a, dac_b, dac_c, dac_d}));

    // R2
    cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> $stable({addr_q, code_q}));
endmodule

bind qdac_front qdac_front_chk u_chk (.*);

// File: tb/sim_qdac_front.sv
`timescale 1ns/1ps
module sim_qdac_front;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sdi = 1'b0, sclk = 1'b0, cs_n = 1'b1, ld_n = 1'b1, clr_n = 1'b1, clr_mid = 1'b0;
    logic [11:0] dac_a, dac_b, dac_c, dac_d;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] m_sr = '0;
    logic [11:0] m_ch [4] = '{default: '0};

    always #2.5 clk = ~clk;

    qdac_front u0 (
        .clk(clk), .rst_n(rst_n), .sdi(sdi), .sclk(sclk), .cs_n(cs_n),
        .ld_n(ld_n), .clr_n(clr_n), .clr_mid(clr_mid),
        .dac_a(dac_a), .dac_b(dac_b), .dac_c(dac_c), .dac_d(dac_d)
    );

    task automatic hold(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check_all(input string req);
        logic [11:0] act [4];
        act[0] = dac_a; act[1] = dac_b; act[2] = dac_c; act[3] = dac_d;
        for (int i = 0; i < 4; i++) begin
            n_chk++;
            if (act[i] !== m_ch[i]) begin
                n_bad++;
                $display("FAIL %s channel %0d: actual %h expected %h", req, i, act[i], m_ch[i]);
            end
        end
    endtask

    task automatic shift_bit(input logic b);
        sdi = b;
        hold(3);
        sclk = 1'b1;
        if (!cs_n) m_sr = {m_sr[14:0], b};
        hold(3);
        sclk = 1'b0;
        hold(3);
    endtask

    task automatic send_bits(input logic [31:0] w, input int nbits, input logic sel);
        cs_n = !sel;
        hold(2);
        for (int i = nbits - 1; i >= 0; i--) shift_bit(w[i]);
        cs_n = 1'b1;
        hold(2);
    endtask

    task automatic pulse_load();
        ld_n = 1'b0;
        hold(5);
        if (clr_n) m_ch[m_sr[15:14]] = m_sr[11:0];
        ld_n = 1'b1;
        hold(5);
    endtask

    function automatic logic [15:0] mk(input logic [1:0] a, input logic [11:0] c);
        return {a, 2'b00, c};
    endfunction

    // R8
    task automatic t_reset();
        check_all("R8 reset");
        pulse_load();
        check_all("R8 empty shift register");
    endtask

    // R1 R3 R4 R10
    task automatic t_each_channel();
        logic [11:0] codes [4] = '{12'h123, 12'hA5C, 12'h7FF, 12'hF01};
        for (int ch = 0; ch < 4; ch++) begin
            send_bits({16'h0, mk(2'(ch), codes[ch])}, 16, 1'b1);
            pulse_load();
            check_all("R1 R3 R4 addressed write");
        end
    endtask

    // R2
    task automatic t_cs_high();
        send_bits({16'h0, mk(2'd1, 12'h5A5)}, 16, 1'b1);
        send_bits({16'h0, mk(2'd2, 12'h3C3)}, 16, 1'b0);
        pulse_load();
        check_all("R2 shifting with select high");
    endtask

    // R3
    task automatic t_load_cs_low();
        send_bits({16'h0, mk(2'd3, 12'h0F0)}, 16, 1'b1);
        cs_n = 1'b0;
        hold(3);
        pulse_load();
        cs_n = 1'b1;
        hold(3);
        check_all("R3 load with select low");
    endtask

    // R5
    task automatic do_clear(input logic mid, input string req);
        clr_mid = mid;
        hold(3);
        clr_n = 1'b0;
        hold(5);
        for (int i = 0; i < 4; i++) m_ch[i] = mid ? 12'h800 : 12'h000;
        check_all(req);
        clr_n = 1'b1;
        hold(5);
        check_all(req);
    endtask

    // R6
    task automatic t_clear_keeps_sr();
        send_bits({16'h0, mk(2'd3, 12'hABC)}, 16, 1'b1);
        do_clear(1'b0, "R6 clear");
        pulse_load();
        check_all("R6 shift register survives clear");
    endtask

    // R7
    task automatic t_clear_priority();
        send_bits({16'h0, mk(2'd0, 12'h999)}, 16, 1'b1);
        clr_mid = 1'b1;
        hold(3);
        clr_n = 1'b0;
        hold(4);
        for (int i = 0; i < 4; i++) m_ch[i] = 12'h800;
        pulse_load();
        check_all("R7 load under clear");
        clr_n = 1'b1;
        hold(5);
        check_all("R7 after clear release");
    endtask

    // R9
    task automatic t_long_word();
        send_bits({12'hFAB, mk(2'd2, 12'h246)}, 20, 1'b1);
        pulse_load();
        check_all("R9 overlong word");
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #1;
        hold(3);
        rst_n = 1'b1;
        hold(4);
        t_reset();
        t_each_channel();
        t_cs_high();
        t_load_cs_low();
        do_clear(1'b1, "R5 clear to midscale");
        t_each_channel();
        do_clear(1'b0, "R5 clear to zero");
        t_clear_keeps_sr();
        t_clear_priority();
        t_long_word();
        report();
    end

    initial begin
        #500000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        report();
    end
endmodule